// File: doc/BRIEF.md
# Synchronous Exception Entry Controller

This block sits at the writeback stage of a small 32-bit in-order core and performs entry into three synchronous exceptions: the floating-point-enabled program exception, the floating-point-unavailable exception and the system call. In every cycle it looks at the instruction in writeback and the current machine state, and selects at most one exception by fixed priority. It suppresses that instruction in the same cycle and then performs the entry on the next clock edge. The entry saves the return address and the old machine state, writes the new machine state, records program syndrome bits and sends the handler address to fetch.

The handler address is built from fields, not taken from a fixed table. A 16-bit prefix field comes first, then the 12-bit offset field that belongs to the selected exception, then four zero bits. Only the critical-enable, machine-check-enable and debug-enable bits of the machine state pass through entry; every other bit is cleared. A floating-point instruction that updates the condition register and takes a precise program exception does not update the condition register. Instead, the block records a syndrome so that the handler can make that update in software.

Top module: `exc_entry_ctrl`

## Requirements
- R1: During and right after reset, `redirect_valid`, `flush` and `msr_we` are 0, and `srr0`, `srr1` and `syndrome` are 0.
- R2: A floating-point-unavailable entry is taken only when `wb_valid`=1, `wb_is_fp`=1, no program request is present and bit 13 (FP enable) of `msr` is 0. If bit 13 is 1, the instruction proceeds with no entry.
- R3: On the cycle after an entry, `redirect_pc` equals {`vec_prefix`, offset, 4'b0000}. The offset is `off_prog` for a program exception, `off_fpu` for floating-point-unavailable and `off_sc` for a system call.
- R4: On a program or floating-point-unavailable entry, `srr0` is loaded with `wb_pc`, so that the suppressed instruction runs again after return.
- R5: On a system call entry, `srr0` is loaded with `wb_pc` + 4.
- R6: On every entry, `srr1` is loaded with the value of `msr` that was present in the cycle of the request.
- R7: On the cycle after an entry, `msr_we` is 1 and `msr_next` holds the old `msr` with bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) kept and all other bits cleared.
- R8: On a program entry, `syndrome` is loaded with bit 4 = `wb_cr_upd`, bit 3 = `wb_cr_cmp` and bits 2:0 = `wb_cr_fld`. Other entry types leave `syndrome` unchanged.
- R9: Priority is fixed: program, then floating-point-unavailable, then system call. `wb_kill` is 1 combinationally in the cycle in which any entry is selected, and at most one entry is taken per cycle.
- R10: `redirect_valid` and `flush` are 1 for exactly the one cycle after each selected entry and are 0 otherwise.
- R11: If no entry is selected, for example because `wb_valid`=0, then `srr0`, `srr1` and `syndrome` keep their values and `msr_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wb_valid | input | 1 | A valid instruction is in writeback |
| wb_pc | input | 32 | Address of the writeback instruction |
| wb_prog_req | input | 1 | Precise floating-point-enabled program exception request |
| wb_is_fp | input | 1 | Instruction recognised as floating-point |
| wb_is_sc | input | 1 | Instruction is a system call |
| wb_cr_upd | input | 1 | Instruction would have updated the condition register |
| wb_cr_cmp | input | 1 | Instruction is a compare type |
| wb_cr_fld | input | 3 | Target condition-register field number |
| msr | input | 32 | Current machine state |
| vec_prefix | input | 16 | Vector prefix field |
| off_prog | input | 12 | Offset field for program exception |
| off_fpu | input | 12 | Offset field for floating-point-unavailable |
| off_sc | input | 12 | Offset field for system call |
| wb_kill | output | 1 | Suppress the writeback instruction (combinational) |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Handler address |
| flush | output | 1 | One-cycle pulse that cancels younger instructions |
| msr_we | output | 1 | Write enable for the machine state |
| msr_next | output | 32 | New machine state value |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved machine state |
| syndrome | output | 5 | Program syndrome {cr_upd, cmp, field[2:0]} |

## Verification
A wrong priority choice or a wrong suppression decision shows up at `wb_kill` in the same cycle. On the next edge it also appears as the wrong offset in `redirect_pc` and the wrong return address in `srr0`. A save register that is written when it should hold, or held when it should be written, shows on `srr0`, `srr1` or `syndrome` one cycle after the stimulus. The value stays visible until the next entry, so later checks see it as well. A mask error in the machine-state update shows on `msr_next` in that same cycle after the entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [1:0] {
      EXC_NONE = 2'd0,
      EXC_PROG = 2'd1,
      EXC_FPU  = 2'd2,
      EXC_SC   = 2'd3
   } exc_kind_e;
endpackage

// File: rtl/exc_pick.sv
module exc_pick
   import exc_entry_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int FP_BIT = 13
) (
   input  logic            wb_valid,
   input  logic            prog_req,
   input  logic            is_fp,
   input  logic            is_sc,
   input  logic [XLEN-1:0] msr,
   output exc_kind_e       kind,
   output logic [2:0]      sel,
   output logic            take
);
   logic fp_off;
   assign fp_off = ~msr[FP_BIT];

   always_comb begin
      sel  = 3'b000;
      kind = EXC_NONE;
      if (wb_valid) begin
         if (prog_req) begin
            sel[0] = 1'b1;
            kind   = EXC_PROG;
         end else if (is_fp && fp_off) begin
            sel[1] = 1'b1;
            kind   = EXC_FPU;
         end else if (is_sc) begin
            sel[2] = 1'b1;
            kind   = EXC_SC;
         end
      end
   end

   assign take = |sel;
endmodule

// File: rtl/exc_vector.sv
module exc_vector
   import exc_entry_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter int PREFIX_W = 16,
   parameter int OFFSET_W = 12,
   parameter int ALIGN_W  = 4
) (
   input  exc_kind_e           kind,
   input  logic [PREFIX_W-1:0] prefix,
   input  logic [OFFSET_W-1:0] off_prog,
   input  logic [OFFSET_W-1:0] off_fpu,
   input  logic [OFFSET_W-1:0] off_sc,
   output logic [XLEN-1:0]     vec
);
   localparam int SUM_W = PREFIX_W + OFFSET_W + ALIGN_W;

   if (SUM_W != XLEN) begin : g_bad_width
      $error("exc_vector: prefix, offset and alignment widths must add up to XLEN");
   end

   logic [OFFSET_W-1:0] off_sel;

   always_comb begin
      unique case (kind)
         EXC_PROG: off_sel = off_prog;
         EXC_FPU:  off_sel = off_fpu;
         EXC_SC:   off_sel = off_sc;
         default:  off_sel = '0;
      endcase
   end

   assign vec = {prefix, off_sel, {ALIGN_W{1'b0}}};
endmodule

// File: rtl/exc_state_save.sv
module exc_state_save
   import exc_entry_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int ILEN_BYTES   = 4,
   parameter int CE_BIT       = 17,
   parameter int ME_BIT       = 12,
   parameter int DE_BIT       = 9,
   parameter int SYN_W        = 5,
   parameter bit HAS_SYNDROME = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  exc_kind_e        kind,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  msr,
   input  logic [XLEN-1:0]  vec,
   input  logic [SYN_W-1:0] syn_in,
   output logic             redirect_valid,
   output logic [XLEN-1:0]  redirect_pc,
   output logic             flush,
   output logic             msr_we,
   output logic [XLEN-1:0]  msr_next,
   output logic [XLEN-1:0]  srr0,
   output logic [XLEN-1:0]  srr1,
   output logic [SYN_W-1:0] syndrome
);
   localparam logic [XLEN-1:0] KEEP_MASK =
      (XLEN'(1) << CE_BIT) | (XLEN'(1) << ME_BIT) | (XLEN'(1) << DE_BIT);
   localparam logic [XLEN-1:0] STEP = XLEN'(ILEN_BYTES);

   if (CE_BIT >= XLEN || ME_BIT >= XLEN || DE_BIT >= XLEN) begin : g_bad_bits
      $error("exc_state_save: kept machine-state bits must lie inside XLEN");
   end

   logic [XLEN-1:0] ret_addr;
   assign ret_addr = (kind == EXC_SC) ? (pc + STEP) : pc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         flush          <= 1'b0;
         msr_we         <= 1'b0;
         redirect_pc    <= '0;
         msr_next       <= '0;
         srr0           <= '0;
         srr1           <= '0;
      end else begin
         redirect_valid <= take;
         flush          <= take;
         msr_we         <= take;
         if (take) begin
            redirect_pc <= vec;
            msr_next    <= msr & KEEP_MASK;
            srr0        <= ret_addr;
            srr1        <= msr;
         end
      end
   end

   if (HAS_SYNDROME) begin : g_syn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            syndrome <= '0;
         else if (take && kind == EXC_PROG)
            syndrome <= syn_in;
      end
   end else begin : g_no_syn
      logic unused_syn;
      assign unused_syn = ^syn_in;
      assign syndrome   = '0;
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int XLEN         = 32,
   parameter int PREFIX_W     = 16,
   parameter int OFFSET_W     = 12,
   parameter int ALIGN_W      = 4,
   parameter int ILEN_BYTES   = 4,
   parameter int FP_BIT       = 13,
   parameter int CE_BIT       = 17,
   parameter int ME_BIT       = 12,
   parameter int DE_BIT       = 9,
   parameter int CRF_W        = 3,
   parameter bit HAS_SYNDROME = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wb_valid,
   input  logic [XLEN-1:0]     wb_pc,
   input  logic                wb_prog_req,
   input  logic                wb_is_fp,
   input  logic                wb_is_sc,
   input  logic                wb_cr_upd,
   input  logic                wb_cr_cmp,
   input  logic [CRF_W-1:0]    wb_cr_fld,
   input  logic [XLEN-1:0]     msr,
   input  logic [PREFIX_W-1:0] vec_prefix,
   input  logic [OFFSET_W-1:0] off_prog,
   input  logic [OFFSET_W-1:0] off_fpu,
   input  logic [OFFSET_W-1:0] off_sc,
   output logic                wb_kill,
   output logic                redirect_valid,
   output logic [XLEN-1:0]     redirect_pc,
   output logic                flush,
   output logic                msr_we,
   output logic [XLEN-1:0]     msr_next,
   output logic [XLEN-1:0]     srr0,
   output logic [XLEN-1:0]     srr1,
   output logic [CRF_W+1:0]    syndrome
);
   localparam int SYN_W = CRF_W + 2;

   if (FP_BIT >= XLEN) begin : g_bad_fp
      $error("exc_entry_ctrl: FP_BIT outside XLEN");
   end

   exc_kind_e        kind;
   logic [2:0]       sel;
   logic             take;
   logic [XLEN-1:0]  vec;
   logic [SYN_W-1:0] syn_in;

   assign syn_in  = {wb_cr_upd, wb_cr_cmp, wb_cr_fld};
   assign wb_kill = take;

   exc_pick #(.XLEN(XLEN), .FP_BIT(FP_BIT)) u_pick (
      .wb_valid (wb_valid),
      .prog_req (wb_prog_req),
      .is_fp    (wb_is_fp),
      .is_sc    (wb_is_sc),
      .msr      (msr),
      .kind     (kind),
      .sel      (sel),
      .take     (take)
   );

   exc_vector #(.XLEN(XLEN), .PREFIX_W(PREFIX_W), .OFFSET_W(OFFSET_W),
                .ALIGN_W(ALIGN_W)) u_vec (
      .kind     (kind),
      .prefix   (vec_prefix),
      .off_prog (off_prog),
      .off_fpu  (off_fpu),
      .off_sc   (off_sc),
      .vec      (vec)
   );

   exc_state_save #(.XLEN(XLEN), .ILEN_BYTES(ILEN_BYTES), .CE_BIT(CE_BIT),
                    .ME_BIT(ME_BIT), .DE_BIT(DE_BIT), .SYN_W(SYN_W),
                    .HAS_SYNDROME(HAS_SYNDROME)) u_save (
      .clk            (clk),
      .rst_n          (rst_n),
      .take           (take),
      .kind           (kind),
      .pc             (wb_pc),
      .msr            (msr),
      .vec            (vec),
      .syn_in         (syn_in),
      .redirect_valid (redirect_valid),
      .redirect_pc    (redirect_pc),
      .flush          (flush),
      .msr_we         (msr_we),
      .msr_next       (msr_next),
      .srr0           (srr0),
      .srr1           (srr1),
      .syndrome       (syndrome)
   );
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int XLEN     = 32,
   parameter int PREFIX_W = 16,
   parameter int ALIGN_W  = 4,
   parameter int FP_BIT   = 13,
   parameter int CE_BIT   = 17,
   parameter int ME_BIT   = 12,
   parameter int DE_BIT   = 9
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wb_valid,
   input logic                wb_is_fp,
   input logic                wb_prog_req,
   input logic                wb_kill,
   input logic [2:0]          sel,
   input logic [XLEN-1:0]     msr,
   input logic [PREFIX_W-1:0] vec_prefix,
   input logic                redirect_valid,
   input logic [XLEN-1:0]     redirect_pc,
   input logic                flush,
   input logic                msr_we,
   input logic [XLEN-1:0]     msr_next,
   input logic [XLEN-1:0]     srr0,
   input logic [XLEN-1:0]     srr1
);
   localparam logic [XLEN-1:0] KEEP =
      (XLEN'(1) << CE_BIT) | (XLEN'(1) << ME_BIT) | (XLEN'(1) << DE_BIT);

   // R9
   one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel) && (wb_kill == (sel != 3'b000)));

   // R10
   pulse_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_kill |=> (redirect_valid && flush));

   // R10
   no_spurious_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_kill |=> (!redirect_valid && !flush));

   // R6
   srr1_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_kill |=> (srr1 == $past(msr)));

   // R7
   msr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_kill |=> (msr_next == ($past(msr) & KEEP)));

   // R3
   vector_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_kill |=> (redirect_pc[ALIGN_W-1:0] == '0 &&
                   redirect_pc[XLEN-1 -: PREFIX_W] == $past(vec_prefix)));

   // R11
   hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wb_kill |=> ($stable(srr0) && $stable(srr1) && !msr_we));

   // R2
   fp_enabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && wb_is_fp && !wb_prog_req && msr[FP_BIT]) |-> !sel[1]);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .XLEN(XLEN), .PREFIX_W(PREFIX_W), .ALIGN_W(ALIGN_W), .FP_BIT(FP_BIT),
   .CE_BIT(CE_BIT), .ME_BIT(ME_BIT), .DE_BIT(DE_BIT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wb_valid       (wb_valid),
   .wb_is_fp       (wb_is_fp),
   .wb_prog_req    (wb_prog_req),
   .wb_kill        (wb_kill),
   .sel            (sel),
   .msr            (msr),
   .vec_prefix     (vec_prefix),
   .redirect_valid (redirect_valid),
   .redirect_pc    (redirect_pc),
   .flush          (flush),
   .msr_we         (msr_we),
   .msr_next       (msr_next),
   .srr0           (srr0),
   .srr1           (srr1)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wb_valid = 1'b0;
   logic [31:0] wb_pc = '0;
   logic        wb_prog_req = 1'b0;
   logic        wb_is_fp = 1'b0;
   logic        wb_is_sc = 1'b0;
   logic        wb_cr_upd = 1'b0;
   logic        wb_cr_cmp = 1'b0;
   logic [2:0]  wb_cr_fld = '0;
   logic [31:0] msr = '0;
   logic [15:0] vec_prefix = 16'hC0DE;
   logic [11:0] off_prog = 12'h061;
   logic [11:0] off_fpu = 12'h072;
   logic [11:0] off_sc = 12'h083;
   logic        wb_kill;
   logic        redirect_valid;
   logic [31:0] redirect_pc;
   logic        flush;
   logic        msr_we;
   logic [31:0] msr_next;
   logic [31:0] srr0;
   logic [31:0] srr1;
   logic [4:0]  syndrome;

   localparam logic [31:0] KEEP = (32'd1 << 17) | (32'd1 << 12) | (32'd1 << 9);

   typedef struct packed {
      logic        rv;
      logic [31:0] vec;
      logic [31:0] s0;
      logic [31:0] s1;
      logic [4:0]  syn;
      logic [31:0] mn;
   } exp_t;

   exp_t        q[$];
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;
   logic [31:0] m_s0 = '0;
   logic [31:0] m_s1 = '0;
   logic [4:0]  m_syn = '0;

   exc_entry_ctrl u_exc_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_pc(wb_pc),
      .wb_prog_req(wb_prog_req), .wb_is_fp(wb_is_fp), .wb_is_sc(wb_is_sc),
      .wb_cr_upd(wb_cr_upd), .wb_cr_cmp(wb_cr_cmp), .wb_cr_fld(wb_cr_fld),
      .msr(msr), .vec_prefix(vec_prefix), .off_prog(off_prog),
      .off_fpu(off_fpu), .off_sc(off_sc), .wb_kill(wb_kill),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .flush(flush), .msr_we(msr_we), .msr_next(msr_next),
      .srr0(srr0), .srr1(srr1), .syndrome(syndrome)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: applies one writeback cycle and pushes the predicted result
   task automatic drive(input logic v, input logic pr, input logic fp, input logic sc,
                        input logic [31:0] m, input logic [31:0] pc,
                        input logic cu, input logic cc, input logic [2:0] cf);
      logic tp, tf, ts;
      exp_t e;
      @(negedge clk);
      wb_valid = v; wb_prog_req = pr; wb_is_fp = fp; wb_is_sc = sc;
      msr = m; wb_pc = pc; wb_cr_upd = cu; wb_cr_cmp = cc; wb_cr_fld = cf;
      tp = v & pr;
      tf = v & fp & ~m[13] & ~tp;
      ts = v & sc & ~tp & ~tf;
      e = '0;
      e.rv = tp | tf | ts;
      if (tp) e.vec = {vec_prefix, off_prog, 4'h0};
      if (tf) e.vec = {vec_prefix, off_fpu, 4'h0};
      if (ts) e.vec = {vec_prefix, off_sc, 4'h0};
      if (tp | tf) m_s0 = pc;
      if (ts) m_s0 = pc + 32'd4;
      if (e.rv) m_s1 = m;
      if (tp) m_syn = {cu, cc, cf};
      e.s0 = m_s0; e.s1 = m_s1; e.syn = m_syn;
      e.mn = m & KEEP;
      q.push_back(e);
      #1;
      check("R9 R2 wb_kill", {31'd0, wb_kill}, {31'd0, e.rv});
   endtask

   task automatic idle();
      drive(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 3'd0);
   endtask

   // monitor: pops one predicted item per clock edge
   always @(posedge clk) begin
      #5;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check("R10 redirect_valid", {31'd0, redirect_valid}, {31'd0, e.rv});
         check("R10 flush", {31'd0, flush}, {31'd0, e.rv});
         check("R7 R11 msr_we", {31'd0, msr_we}, {31'd0, e.rv});
         if (e.rv) begin
            check("R3 redirect_pc", redirect_pc, e.vec);
            check("R7 msr_next", msr_next, e.mn);
         end
         check("R4 R5 srr0", srr0, e.s0);
         check("R6 srr1", srr1, e.s1);
         check("R8 syndrome", {27'd0, syndrome}, {27'd0, e.syn});
      end
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         errors++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      // R1 reset state
      check("R1 redirect_valid", {31'd0, redirect_valid}, 32'd0);
      check("R1 flush", {31'd0, flush}, 32'd0);
      check("R1 msr_we", {31'd0, msr_we}, 32'd0);
      check("R1 srr0", srr0, 32'd0);
      check("R1 srr1", srr1, 32'd0);
      check("R1 syndrome", {27'd0, syndrome}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #5;
      check("R1 after release", {31'd0, redirect_valid}, 32'd0);

      // R2 R4 R6 R7: floating-point-unavailable with FP enable clear
      drive(1'b1, 1'b0, 1'b1, 1'b0, 32'hFFFF_DFFF, 32'h0000_1000, 1'b0, 1'b0, 3'd0);
      idle();
      // R2 R11: FP enable set, no entry
      drive(1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_2000, 32'h0000_1100, 1'b0, 1'b0, 3'd0);
      // R5: system call
      drive(1'b1, 1'b0, 1'b0, 1'b1, 32'h0002_1200, 32'h0000_2004, 1'b0, 1'b0, 3'd0);
      // R8: program exception with syndrome
      drive(1'b1, 1'b1, 1'b1, 1'b0, 32'h8000_3A00, 32'h0000_3008, 1'b1, 1'b1, 3'd5);
      // R9: all three together, program wins
      drive(1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_4000, 1'b1, 1'b0, 3'd2);
      // R9: FP-unavailable beats system call; R8 syndrome held
      drive(1'b1, 1'b0, 1'b1, 1'b1, 32'h0001_0200, 32'h0000_5000, 1'b0, 1'b1, 3'd7);
      // R11: wb_valid low, nothing changes
      drive(1'b0, 1'b1, 1'b1, 1'b1, 32'h1234_5678, 32'h0000_6000, 1'b1, 1'b1, 3'd1);
      // R10: back-to-back system calls, then idle ends the pulses
      drive(1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 1'b0, 1'b0, 3'd0);
      drive(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_7000, 1'b0, 1'b0, 3'd0);
      idle();
      idle();
      while (q.size() > 0) @(posedge clk);
      #8;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule